// File: doc/BRIEF.md
# Phase Configuration Rule Checker

This block decides whether a table that maps output pins to two power channels is legal before that table is put into use. The table has one entry per pin position. Each entry carries an enable bit, a channel select, a phase number and a firing-order number. Channel A uses the low pin positions and numbers its phases upward from position 0. Channel B shares the upper end of channel A's range and numbers its phases downward from its own first pin. The checker ignores disabled entries completely. It checks each channel against its phase limit, its firing-order rules, its phase-numbering rules and its allowed pin window.

A host writes the table, holds it stable and pulses `start`. The checker then walks the entries, one position per clock. It keeps a small summary for each channel: the count of enabled entries, a mask of the order values seen, a mask of the phase values seen, and sticky flags for numbering and placement errors. One clock after the walk it reports a per-channel error vector and an overall `valid`, and pulses `done`. The checker only reads the table and never changes it.

Top module: `phasecfg_checker`

## Requirements
- R1: Channel A is every enabled entry with its channel bit at 0. If channel A holds more than `A_MAX` entries (default 7), error bit 0 of `err_a` is set.
- R2: Channel B is every enabled entry with its channel bit at 1. If channel B holds more than `B_MAX` entries (default 3), error bit 0 of `err_b` is set.
- R3: Error bit 1 is set when a channel has at least one entry but no entry with order value 0.
- R4: Error bit 2 is set when a channel's order values leave a hole, meaning some value v is missing while values both below and above v are present.
- R5: Error bit 3 is set when the k-th enabled entry of a channel does not carry phase k, counting k from 0. Channel A counts from position 0 upward. Channel B counts from position N_ENT-1 downward.
- R6: Error bit 4 is set when two entries of one channel share an order value. Error bit 5 is set when two entries of one channel share a phase value.
- R7: A disabled entry affects no result, whatever its channel, phase and order fields hold. A channel with no enabled entries raises no error bit.
- R8: Error bit 6 is set when a channel A entry sits above position `A_LAST` (default 6). It is also set when a channel B entry sits outside positions `B_FIRST-B_MAX+1` to `B_FIRST` (default 4 to 6).
- R9: `done` is high for exactly one clock. It rises on the N_ENT+1-th rising edge after the edge that accepts `start`.
- R10: An accepted `start` clears `valid`, `err_a` and `err_b` on the same edge. After that, the outputs change only at the `done` edge. A `start` that arrives while a check is running is ignored. All outputs are 0 after reset.
- R11: `valid` is 1 exactly when no bit of `err_a` or `err_b` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a check when the block is idle |
| ent_en | input | N_ENT | Enable bit per pin position |
| ent_page | input | N_ENT | Channel select per position (0 = A, 1 = B) |
| ent_phase | input | N_ENT*IDX_W | Phase number per position, position i at bits [i*IDX_W +: IDX_W] |
| ent_order | input | N_ENT*IDX_W | Firing order per position, same packing as ent_phase |
| done | output | 1 | One-clock pulse when a result is ready |
| valid | output | 1 | Table legal (held until the next accepted start) |
| err_a | output | 7 | Channel A error bits |
| err_b | output | 7 | Channel B error bits |

## Verification
Directed tables each break one rule on one channel. Examples include order sets {1,2} and {0,2}, swapped phases, duplicate orders or phases, an entry outside its pin window, and over-full channels. These tables show that each error bit fires on its own fault and not on a neighbouring one. Channel B tables numbered upward rather than downward show whether the scan direction is correct. An empty table and a legal table full of garbage in disabled entries confirm that disabled fields are ignored. A second start pulse during a scan, together with many pseudo-random tables compared clock by clock against a behavioural model, checks the timing of done and valid and the rule mix under combined faults.

// File: rtl/phasecfg_pkg.sv
package phasecfg_pkg;
   localparam int NUM_ERR      = 7;
   localparam int ERR_OVER     = 0;
   localparam int ERR_ORD_BASE = 1;
   localparam int ERR_ORD_GAP  = 2;
   localparam int ERR_PH_SEQ   = 3;
   localparam int ERR_DUP_ORD  = 4;
   localparam int ERR_DUP_PH   = 5;
   localparam int ERR_PLACE    = 6;

   typedef logic [NUM_ERR-1:0] err_vec_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_EVAL = 2'd2
   } scan_st_e;
endpackage

// File: rtl/phasecfg_seq.sv
module phasecfg_seq
   import phasecfg_pkg::*;
#(
   parameter int N_ENT = 12,
   localparam int PW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          clr,
   output logic          step,
   output logic          finish,
   output logic [PW-1:0] ptr
);
   scan_st_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         ptr <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st  <= ST_SCAN;
                  ptr <= '0;
               end
            end
            ST_SCAN: begin
               if (ptr == PW'(N_ENT - 1)) st <= ST_EVAL;
               else                       ptr <= ptr + 1'b1;
            end
            ST_EVAL: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign clr    = (st == ST_IDLE) && start;
   assign step   = (st == ST_SCAN);
   assign finish = (st == ST_EVAL);
endmodule

// File: rtl/phasecfg_judge.sv
module phasecfg_judge
   import phasecfg_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int CW     = 4,
   parameter int MAX_PH = 7,
   localparam int MW    = 1 << IDX_W
) (
   input  logic [CW-1:0] cnt,
   input  logic [MW-1:0] omask,
   input  logic [MW-1:0] pmask,
   input  logic          seq_err,
   input  logic          place_err,
   output err_vec_t      err
);
   logic [MW-1:0] hole;

   assign hole[0]    = 1'b0;
   assign hole[MW-1] = 1'b0;

   genvar v;
   generate
      for (v = 1; v < MW - 1; v++) begin : g_hole
         assign hole[v] = !omask[v] && (|omask[v-1:0]) && (|omask[MW-1:v+1]);
      end
   endgenerate

   always_comb begin
      err               = '0;
      err[ERR_OVER]     = int'(cnt) > MAX_PH;
      err[ERR_ORD_BASE] = (cnt != '0) && !omask[0];
      err[ERR_ORD_GAP]  = |hole;
      err[ERR_PH_SEQ]   = seq_err;
      err[ERR_DUP_ORD]  = $countones(omask) != int'(cnt);
      err[ERR_DUP_PH]   = $countones(pmask) != int'(cnt);
      err[ERR_PLACE]    = place_err;
   end
endmodule

// File: rtl/phasecfg_lane.sv
module phasecfg_lane
   import phasecfg_pkg::*;
#(
   parameter int   N_ENT    = 12,
   parameter int   IDX_W    = 3,
   parameter int   MAX_PH   = 7,
   parameter int   LO_POS   = 0,
   parameter int   HI_POS   = 6,
   parameter bit   PAGE_SEL = 1'b0,
   parameter bit   DESCEND  = 1'b0,
   localparam int  PW       = (N_ENT > 1) ? $clog2(N_ENT) : 1,
   localparam int  CW       = $clog2(N_ENT + 1),
   localparam int  MW       = 1 << IDX_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   step,
   input  logic [PW-1:0]          ptr,
   input  logic [N_ENT-1:0]       ent_en,
   input  logic [N_ENT-1:0]       ent_page,
   input  logic [N_ENT*IDX_W-1:0] ent_phase,
   input  logic [N_ENT*IDX_W-1:0] ent_order,
   output err_vec_t               err
);
   logic [PW-1:0]    pos;
   logic             hit;
   logic [IDX_W-1:0] ph;
   logic [IDX_W-1:0] od;
   logic [CW-1:0]    cnt;
   logic [MW-1:0]    omask;
   logic [MW-1:0]    pmask;
   logic             seq_err;
   logic             place_err;

   generate
      if (DESCEND) begin : g_down
         assign pos = PW'(N_ENT - 1) - ptr;
      end else begin : g_up
         assign pos = ptr;
      end
   endgenerate

   always_comb begin
      hit = ent_en[pos] && (ent_page[pos] == PAGE_SEL);
      ph  = ent_phase[pos*IDX_W +: IDX_W];
      od  = ent_order[pos*IDX_W +: IDX_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         omask     <= '0;
         pmask     <= '0;
         seq_err   <= 1'b0;
         place_err <= 1'b0;
      end else if (clr) begin
         cnt       <= '0;
         omask     <= '0;
         pmask     <= '0;
         seq_err   <= 1'b0;
         place_err <= 1'b0;
      end else if (step && hit) begin
         cnt       <= cnt + 1'b1;
         omask[od] <= 1'b1;
         pmask[ph] <= 1'b1;
         if (int'(ph) != int'(cnt)) seq_err <= 1'b1;
         if (int'(pos) < LO_POS || int'(pos) > HI_POS) place_err <= 1'b1;
      end
   end

   phasecfg_judge #(
      .IDX_W (IDX_W),
      .CW    (CW),
      .MAX_PH(MAX_PH)
   ) u_judge (
      .cnt      (cnt),
      .omask    (omask),
      .pmask    (pmask),
      .seq_err  (seq_err),
      .place_err(place_err),
      .err      (err)
   );
endmodule

// File: rtl/phasecfg_checker.sv
module phasecfg_checker
   import phasecfg_pkg::*;
#(
   parameter int N_ENT   = 12,
   parameter int IDX_W   = 3,
   parameter int A_MAX   = 7,
   parameter int B_MAX   = 3,
   parameter int A_LAST  = 6,
   parameter int B_FIRST = 6,
   localparam int PW     = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [N_ENT-1:0]       ent_en,
   input  logic [N_ENT-1:0]       ent_page,
   input  logic [N_ENT*IDX_W-1:0] ent_phase,
   input  logic [N_ENT*IDX_W-1:0] ent_order,
   output logic                   done,
   output logic                   valid,
   output logic [NUM_ERR-1:0]     err_a,
   output logic [NUM_ERR-1:0]     err_b
);
   generate
      if (N_ENT < 2 || IDX_W < 2 || A_MAX < 1 || B_MAX < 1 ||
          A_LAST >= N_ENT || B_FIRST >= N_ENT || B_MAX > B_FIRST + 1) begin : g_bad_cfg
         $error("phasecfg_checker: inconsistent parameters");
      end
   endgenerate

   logic          clr;
   logic          step;
   logic          finish;
   logic [PW-1:0] ptr;
   err_vec_t      lane_err [2];

   phasecfg_seq #(.N_ENT(N_ENT)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .clr   (clr),
      .step  (step),
      .finish(finish),
      .ptr   (ptr)
   );

   genvar ch;
   generate
      for (ch = 0; ch < 2; ch++) begin : g_lane
         if (ch == 0) begin : g_a
            phasecfg_lane #(
               .N_ENT(N_ENT), .IDX_W(IDX_W), .MAX_PH(A_MAX),
               .LO_POS(0), .HI_POS(A_LAST), .PAGE_SEL(1'b0), .DESCEND(1'b0)
            ) u_lane (
               .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .ptr(ptr),
               .ent_en(ent_en), .ent_page(ent_page),
               .ent_phase(ent_phase), .ent_order(ent_order),
               .err(lane_err[ch])
            );
         end else begin : g_b
            phasecfg_lane #(
               .N_ENT(N_ENT), .IDX_W(IDX_W), .MAX_PH(B_MAX),
               .LO_POS(B_FIRST - B_MAX + 1), .HI_POS(B_FIRST),
               .PAGE_SEL(1'b1), .DESCEND(1'b1)
            ) u_lane (
               .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .ptr(ptr),
               .ent_en(ent_en), .ent_page(ent_page),
               .ent_phase(ent_phase), .ent_order(ent_order),
               .err(lane_err[ch])
            );
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         valid <= 1'b0;
         err_a <= '0;
         err_b <= '0;
      end else if (clr) begin
         done  <= 1'b0;
         valid <= 1'b0;
         err_a <= '0;
         err_b <= '0;
      end else if (finish) begin
         done  <= 1'b1;
         valid <= ~(|lane_err[0] | |lane_err[1]);
         err_a <= lane_err[0];
         err_b <= lane_err[1];
      end else begin
         done  <= 1'b0;
      end
   end
endmodule

// File: rtl/phasecfg_checker_sva.sv
module phasecfg_checker_sva
   import phasecfg_pkg::*;
#(
   parameter int N_ENT = 12,
   parameter int A_MAX = 7,
   parameter int B_MAX = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [N_ENT-1:0]   ent_en,
   input logic [N_ENT-1:0]   ent_page,
   input logic               done,
   input logic               valid,
   input logic [NUM_ERR-1:0] err_a,
   input logic [NUM_ERR-1:0] err_b
);
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start) && !done) |-> ($stable(valid) && $stable(err_a) && $stable(err_b)));

   assert_over_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err_a[ERR_OVER] == ($countones(ent_en & ~ent_page) > A_MAX)));

   assert_over_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err_b[ERR_OVER] == ($countones(ent_en & ent_page) > B_MAX)));

   assert_empty_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (ent_en == '0)) |-> valid);
endmodule

bind phasecfg_checker phasecfg_checker_sva #(
   .N_ENT(N_ENT), .A_MAX(A_MAX), .B_MAX(B_MAX)
) u_sva (
   .clk(clk), .rst_n(rst_n), .start(start), .ent_en(ent_en), .ent_page(ent_page),
   .done(done), .valid(valid), .err_a(err_a), .err_b(err_b)
);

// File: tb/sim_phasecfg_checker.sv
`timescale 1ns/1ps
module sim_phasecfg_checker;
   localparam int N   = 12;
   localparam int IW  = 3;
   localparam int AMX = 7;
   localparam int BMX = 3;
   localparam int ALS = 6;
   localparam int BFS = 6;
   localparam int OVER = 0, BASE = 1, GAP = 2, SEQ = 3, DORD = 4, DPH = 5, PLC = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [N-1:0]    t_en = '0;
   logic [N-1:0]    t_pg = '0;
   logic [N*IW-1:0] t_ph = '0;
   logic [N*IW-1:0] t_od = '0;
   logic done, valid;
   logic [6:0] err_a, err_b;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   phasecfg_checker u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ent_en(t_en), .ent_page(t_pg), .ent_phase(t_ph), .ent_order(t_od),
      .done(done), .valid(valid), .err_a(err_a), .err_b(err_b)
   );

   task automatic chk(input string req, input int got, input int exp, input string what);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   function automatic logic [6:0] calc_lane(input bit pg, input int maxn,
                                            input int lo, input int hi, input bit desc);
      int q_pos[$];
      int q_ph[$];
      int q_od[$];
      bit so[int];
      bit sp[int];
      logic [6:0] e = '0;
      int mn = 1000;
      int mx = -1;
      for (int s = 0; s < N; s++) begin
         int i = desc ? N - 1 - s : s;
         if (t_en[i] && t_pg[i] == pg) begin
            q_pos.push_back(i);
            q_ph.push_back(int'(t_ph[i*IW +: IW]));
            q_od.push_back(int'(t_od[i*IW +: IW]));
         end
      end
      foreach (q_pos[k]) begin
         so[q_od[k]] = 1'b1;
         sp[q_ph[k]] = 1'b1;
         if (q_od[k] < mn) mn = q_od[k];
         if (q_od[k] > mx) mx = q_od[k];
         if (q_ph[k] != k) e[SEQ] = 1'b1;
         if (q_pos[k] < lo || q_pos[k] > hi) e[PLC] = 1'b1;
      end
      e[OVER] = q_pos.size() > maxn;
      if (q_pos.size() > 0) begin
         e[BASE] = !so.exists(0);
         e[GAP]  = so.num() < (mx - mn + 1);
         e[DORD] = so.num() < q_pos.size();
         e[DPH]  = sp.num() < q_pos.size();
      end
      return e;
   endfunction

   // behavioural reference, advanced at each rising edge
   int m_busy = 0;
   logic m_done = 1'b0, m_valid = 1'b0;
   logic [6:0] m_ea = '0, m_eb = '0, x_ea = '0, x_eb = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 1'b0; m_valid = 1'b0; m_ea = '0; m_eb = '0;
      end else begin
         m_done = 1'b0;
         if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) begin
               m_done = 1'b1;
               m_ea = x_ea;
               m_eb = x_eb;
               m_valid = (x_ea == 0) && (x_eb == 0);
            end
         end else if (start) begin
            m_valid = 1'b0; m_ea = '0; m_eb = '0;
            x_ea = calc_lane(1'b0, AMX, 0, ALS, 1'b0);
            x_eb = calc_lane(1'b1, BMX, BFS - BMX + 1, BFS, 1'b1);
            m_busy = N + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R9",  int'(done),  int'(m_done),  "done vs model");
         chk("R11", int'(valid), int'(m_valid), "valid vs model");
         chk("R1",  int'(err_a), int'(m_ea),    "err_a vs model");
         chk("R2",  int'(err_b), int'(m_eb),    "err_b vs model");
      end
   end

   task automatic clr_tbl();
      t_en = '0; t_pg = '0; t_ph = '0; t_od = '0;
   endtask

   task automatic put(input int i, input bit pg, input int ph, input int od);
      t_en[i] = 1'b1;
      t_pg[i] = pg;
      t_ph[i*IW +: IW] = IW'(ph);
      t_od[i*IW +: IW] = IW'(od);
   endtask

   // pulses start; returns at the low phase after the done edge
   task automatic run(input bit extra);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int k = 0; k < N + 1; k++) begin
         @(negedge clk);
         start = extra && (k == 3);
      end
      chk("R9", int'(done), 1, "done at N+1 edges");
   endtask

   task automatic tail();
      @(negedge clk);
      chk("R9", int'(done), 0, "done one clock only");
      chk("R11", int'(valid), int'((err_a == 0) && (err_b == 0)), "valid vs error bits");
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10", int'({done, valid, err_a, err_b}), 0, "outputs in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", int'({done, valid, err_a, err_b}), 0, "outputs after reset");

      // legal 3+2 table, disabled entries full of garbage (R7, R5, R11)
      clr_tbl();
      put(0, 0, 0, 0); put(1, 0, 1, 2); put(2, 0, 2, 1);
      put(6, 1, 0, 0); put(5, 1, 1, 1);
      t_pg[9] = 1'b1; t_ph[9*IW +: IW] = 3'd7; t_od[3*IW +: IW] = 3'd5;
      run(0);
      chk("R11", int'(valid), 1, "legal 3+2 table");
      chk("R7", int'(err_a | err_b), 0, "garbage in disabled entries");
      tail();

      // empty table
      clr_tbl();
      t_ph = '1; t_od = '1; t_pg = '1;
      run(0);
      chk("R7", int'(valid), 1, "empty table legal");
      tail();

      // too many on A (also placement at 7)
      clr_tbl();
      for (int i = 0; i < 8; i++) put(i, 0, i, i);
      run(0);
      chk("R1", int'(err_a[OVER]), 1, "eight A entries");
      chk("R8", int'(err_a[PLC]), 1, "A entry at position 7");
      tail();

      // too many on B (position 3 outside window)
      clr_tbl();
      put(6, 1, 0, 0); put(5, 1, 1, 1); put(4, 1, 2, 2); put(3, 1, 3, 3);
      run(0);
      chk("R2", int'(err_b[OVER]), 1, "four B entries");
      chk("R8", int'(err_b[PLC]), 1, "B entry at position 3");
      tail();

      // orders {1,2}
      clr_tbl();
      put(0, 0, 0, 1); put(1, 0, 1, 2);
      run(0);
      chk("R3", int'(err_a[BASE]), 1, "no order 0");
      chk("R4", int'(err_a[GAP]), 0, "no hole in {1,2}");
      tail();

      // orders {0,2}
      clr_tbl();
      put(0, 0, 0, 0); put(1, 0, 1, 2);
      run(0);
      chk("R4", int'(err_a[GAP]), 1, "hole in {0,2}");
      chk("R3", int'(err_a[BASE]), 0, "order 0 present");
      tail();

      // swapped phases on A, B numbered upward instead of downward
      clr_tbl();
      put(0, 0, 1, 0); put(1, 0, 0, 1);
      put(5, 1, 0, 0); put(6, 1, 1, 1);
      run(0);
      chk("R5", int'(err_a[SEQ]), 1, "A phases reversed");
      chk("R5", int'(err_b[SEQ]), 1, "B phases counted upward");
      tail();

      // duplicate order
      clr_tbl();
      put(0, 0, 0, 0); put(1, 0, 1, 0);
      run(0);
      chk("R6", int'(err_a[DORD]), 1, "duplicate order");
      chk("R6", int'(err_a[DPH]), 0, "phases distinct");
      tail();

      // duplicate phase on B
      clr_tbl();
      put(6, 1, 0, 0); put(5, 1, 0, 1);
      run(0);
      chk("R6", int'(err_b[DPH]), 1, "duplicate phase");
      chk("R5", int'(err_b[SEQ]), 1, "second B phase not 1");
      tail();

      // placement only, plus ignored second start (R10)
      clr_tbl();
      put(8, 0, 0, 0);
      run(1);
      chk("R8", int'(err_a), 1 << PLC, "A entry at position 8");
      chk("R10", int'(valid), 0, "result after ignored start");
      tail();

      // pseudo-random tables, compared against the model every clock
      for (int r = 0; r < 60; r++) begin
         clr_tbl();
         for (int i = 0; i < N; i++) begin
            if ($urandom_range(0, 2) != 0) begin
               put(i, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 3)));
            end
         end
         run(r[0]);
         tail();
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule